// File: doc/BRIEF.md
# Multichannel SDR Serializer with Mid-Bus Forwarded Clock

This block is the transmit half of a source-synchronous link from a coding sublayer to a line attachment device. Sixteen data lanes each take a J-bit slice of a wide parallel word from the core and send it out one bit per period of a fast bit clock, in single data rate. The bit clock and a word strobe that comes once every J bit-clock cycles are inputs. J is a parameter and may be 4 or 8.

Every lane has two registers. A holding register takes the core word when the strobe is seen. A shift register then sends that word out over the next word period, starting with bit 0. A seventeenth lane is built from the same serializer. It is loaded with a constant alternating pattern and placed in the middle of the output bus, so the forwarded clock goes through the same path as the data and sees the same delay. The receiver takes its sampling edge from that lane.

Top module: `sdr_lane_serializer`

## Requirements
- R1: While `rst_ni` is low, and after reset until the first clock edge that samples `load_i` high, every bit of `tx_o` is 0.
- R2: The word on `word_i` at a load edge goes into the holding register. It is sent during the word period that starts at the next load edge. So the first word period after reset carries 0 on all 17 outputs, including the clock lane.
- R3: In the word period that starts at a load edge, the output of data lane n in the k-th cycle after that edge (k = 0..J-1) is bit k of that lane's slice. Bits leave LSB first, one per bit-clock cycle.
- R4: Data lane n takes `word_i[n*J +: J]`. Lanes 0 to 7 drive `tx_o[0]` to `tx_o[7]`. Lanes 8 to 15 drive `tx_o[9]` to `tx_o[16]`.
- R5: From the second load edge on, `tx_o[8]` carries the forwarded clock. It is 1 in the first cycle of each word period and toggles in every following cycle of that period (1,0,1,0,...). J must be even.
- R6: If no load edge comes within J cycles after a load, the shift registers fill with zeros. All outputs are then 0 until the next load.
- R7: A load edge that comes before J bits have been sent cuts the current word short. The next word starts at bit 0 at once, on data lanes and clock lane alike.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Fast bit clock; one output bit per rising edge |
| rst_ni | input | 1 | Active-low asynchronous reset |
| load_i | input | 1 | Word strobe, normally high once every J cycles |
| word_i | input | 128 | Parallel core word, 16 lanes of J=8 bits, lane n at [n*J +: J] |
| tx_o | output | 17 | Serial outputs: data lanes with the clock lane at index 8 |

## Verification
The bench keeps its own word-level model: the held word, the word being sent, the bit position and the number of loads. It compares all 17 outputs against that model in every cycle. A fault in a holding register shows up one full word period after the load that wrote it. A wrong shift direction or lane mapping shows up within the first two cycles of the next word. A bad clock pattern breaks the toggle on `tx_o[8]` in the very next cycle. A shift register that keeps stale data is caught J cycles after a missing strobe, when the outputs should have drained to zero.

// File: rtl/sertx_pkg.sv
`timescale 1ns/1ps
package sertx_pkg;

  localparam int unsigned MAX_J = 64;

  // Alternating pattern, bit 0 high so the first bit sent is 1
  function automatic logic [MAX_J-1:0] clk_pattern(input int unsigned w);
    logic [MAX_J-1:0] p;
    p = '0;
    for (int unsigned i = 0; i < MAX_J; i++) begin
      if (i < w) p[i] = ~i[0];
    end
    return p;
  endfunction

  function automatic int unsigned clk_slot(input int unsigned lanes);
    return lanes / 2;
  endfunction

endpackage

// File: rtl/ser_lane.sv
`timescale 1ns/1ps
module ser_lane #(
  parameter int unsigned W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] par_i,
  output logic         ser_o
);

  logic [W-1:0] hold_q;
  logic [W-1:0] shift_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hold_q  <= '0;
      shift_q <= '0;
    end else if (load_i) begin
      hold_q  <= par_i;
      shift_q <= hold_q;
    end else begin
      shift_q <= {1'b0, shift_q[W-1:1]};
    end
  end

  assign ser_o = shift_q[0];

endmodule

// File: rtl/ser_clk_pattern.sv
`timescale 1ns/1ps
module ser_clk_pattern #(
  parameter int unsigned W = 8
) (
  output logic [W-1:0] pat_o
);

  localparam logic [W-1:0] PAT = W'(sertx_pkg::clk_pattern(W));

  assign pat_o = PAT;

endmodule

// File: rtl/ser_bus_map.sv
`timescale 1ns/1ps
module ser_bus_map #(
  parameter int unsigned NUM_LANES = 16,
  parameter int unsigned CLK_SLOT  = NUM_LANES / 2
) (
  input  logic [NUM_LANES-1:0] data_i,
  input  logic                 clk_lane_i,
  output logic [NUM_LANES:0]   bus_o
);

  for (genvar s = 0; s <= NUM_LANES; s++) begin : g_slot
    if (s < CLK_SLOT) begin : g_low
      assign bus_o[s] = data_i[s];
    end else if (s == CLK_SLOT) begin : g_clk
      assign bus_o[s] = clk_lane_i;
    end else begin : g_high
      assign bus_o[s] = data_i[s-1];
    end
  end

endmodule

// File: rtl/sdr_lane_serializer.sv
`timescale 1ns/1ps
module sdr_lane_serializer #(
  parameter int unsigned NUM_LANES = 16,
  parameter int unsigned SER_J     = 8
) (
  input  logic                           clk_i,
  input  logic                           rst_ni,
  input  logic                           load_i,
  input  logic [NUM_LANES*SER_J-1:0]     word_i,
  output logic [NUM_LANES:0]             tx_o
);

  localparam int unsigned CLK_SLOT = sertx_pkg::clk_slot(NUM_LANES);

  logic [NUM_LANES-1:0] data_ser;
  logic [SER_J-1:0]     clk_pat;
  logic                 clk_ser;

  for (genvar g = 0; g < NUM_LANES; g++) begin : g_lane
    ser_lane #(.W(SER_J)) u_lane (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .load_i (load_i),
      .par_i  (word_i[g*SER_J +: SER_J]),
      .ser_o  (data_ser[g])
    );
  end

  ser_clk_pattern #(.W(SER_J)) u_pat (
    .pat_o (clk_pat)
  );

  // Same serializer as the data lanes, so the clock sees the same delay
  ser_lane #(.W(SER_J)) u_clk_lane (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (load_i),
    .par_i  (clk_pat),
    .ser_o  (clk_ser)
  );

  ser_bus_map #(.NUM_LANES(NUM_LANES), .CLK_SLOT(CLK_SLOT)) u_map (
    .data_i     (data_ser),
    .clk_lane_i (clk_ser),
    .bus_o      (tx_o)
  );

endmodule

// File: rtl/sertx_chk.sv
`timescale 1ns/1ps
module sertx_chk #(
  parameter int unsigned NUM_LANES = 16,
  parameter int unsigned SER_J     = 8
) (
  input logic                       clk_i,
  input logic                       rst_ni,
  input logic                       load_i,
  input logic [NUM_LANES*SER_J-1:0] word_i,
  input logic [NUM_LANES:0]         tx_o
);

  localparam int unsigned WORD_W   = NUM_LANES * SER_J;
  localparam int unsigned CLK_SLOT = NUM_LANES / 2;
  localparam int unsigned POS_W    = $clog2(SER_J + 1);
  localparam logic [POS_W-1:0] POS_END = POS_W'(SER_J);

  logic [POS_W-1:0]     pos_q;
  logic [1:0]           nload_q;
  logic [WORD_W-1:0]    cap_q, prev_q;
  logic [NUM_LANES-1:0] data_bits, exp_bits;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pos_q   <= POS_END;
      nload_q <= '0;
      cap_q   <= '0;
      prev_q  <= '0;
    end else if (load_i) begin
      pos_q   <= '0;
      nload_q <= (nload_q == 2'd2) ? 2'd2 : nload_q + 2'd1;
      cap_q   <= word_i;
      prev_q  <= cap_q;
    end else if (pos_q != POS_END) begin
      pos_q <= pos_q + 1'b1;
    end
  end

  always_comb begin
    data_bits = '0;
    exp_bits  = '0;
    for (int n = 0; n < int'(NUM_LANES); n++) begin
      data_bits[n] = (n < int'(CLK_SLOT)) ? tx_o[n] : tx_o[n+1];
      if (pos_q < POS_END) exp_bits[n] = prev_q[n*int'(SER_J) + int'(pos_q)];
    end
  end

  a_r1_idle_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (nload_q == 2'd0) |-> (tx_o == '0));

  a_r2_first_word_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (nload_q == 2'd1) |-> (tx_o == '0));

  // R3, R4, R7: lane order, mapping and restart on early strobe
  a_r3_lane_bits: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (nload_q == 2'd2 && pos_q < POS_END) |-> (data_bits == exp_bits));

  a_r5_clk_first_high: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (nload_q == 2'd2 && pos_q == '0) |-> tx_o[CLK_SLOT]);

  a_r5_clk_toggle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (nload_q == 2'd2 && pos_q != '0 && pos_q < POS_END)
      |-> (tx_o[CLK_SLOT] != $past(tx_o[CLK_SLOT])));

  a_r6_drain_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pos_q == POS_END) |-> (tx_o == '0));

endmodule

bind sdr_lane_serializer sertx_chk #(.NUM_LANES(NUM_LANES), .SER_J(SER_J)) u_chk (
  .clk_i  (clk_i),
  .rst_ni (rst_ni),
  .load_i (load_i),
  .word_i (word_i),
  .tx_o   (tx_o)
);

// File: tb/sdr_lane_serializer_tb.sv
`timescale 1ns/1ps
module sdr_lane_serializer_tb;

  localparam int NUM_LANES  = 16;
  localparam int SER_J      = 8;
  localparam int WORD_W     = NUM_LANES * SER_J;
  localparam int BUS_W      = NUM_LANES + 1;
  localparam int CLK_SLOT   = 8;
  localparam int CLK_PERIOD = 10;

  logic              clk = 1'b0;
  logic              rst_n;
  logic              load;
  logic [WORD_W-1:0] word;
  logic [BUS_W-1:0]  tx;

  logic [WORD_W-1:0] m_hold, m_cur;
  int                m_pos, m_loads;
  string             tag;
  int                checks = 0, fails = 0;
  bit                done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sdr_lane_serializer #(.NUM_LANES(NUM_LANES), .SER_J(SER_J)) u_dut (
    .clk_i  (clk),
    .rst_ni (rst_n),
    .load_i (load),
    .word_i (word),
    .tx_o   (tx)
  );

  function automatic logic [WORD_W-1:0] rand_word();
    return {$urandom, $urandom, $urandom, $urandom};
  endfunction

  task automatic check_bus();
    logic [BUS_W-1:0] e;
    e = '0;
    for (int n = 0; n < NUM_LANES; n++) begin
      logic b;
      b = (m_pos < SER_J) ? m_cur[n*SER_J + m_pos] : 1'b0;
      if (n < CLK_SLOT) e[n] = b;
      else e[n+1] = b;
    end
    e[CLK_SLOT] = (m_loads >= 2 && m_pos < SER_J) ? (m_pos % 2 == 0) : 1'b0;
    checks++;
    if (tx !== e) begin
      fails++;
      $display("FAIL %s: tx_o=%h expected %h (pos %0d)", tag, tx, e, m_pos);
    end
  endtask

  task automatic step(input bit ld, input logic [WORD_W-1:0] w);
    load = ld;
    word = w;
    @(posedge clk);
    if (ld) begin
      m_cur  = m_hold;
      m_hold = w;
      m_pos  = 0;
      if (m_loads < 2) m_loads++;
    end else if (m_pos < SER_J) begin
      m_pos++;
    end
    @(negedge clk);
    check_bus();
  endtask

  task automatic send_word(input logic [WORD_W-1:0] w);
    step(1'b1, w);
    repeat (SER_J-1) step(1'b0, rand_word());
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", checks - fails, checks);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: run hung, actual running expected done");
      summary();
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5E71A1));
    m_hold = '0; m_cur = '0; m_pos = SER_J; m_loads = 0;
    rst_n = 1'b0; load = 1'b0; word = '1;

    // R1: quiet during and after reset, before any strobe
    tag = "R1";
    repeat (3) @(negedge clk);
    check_bus();
    rst_n = 1'b1;
    repeat (4) step(1'b0, rand_word());

    // R2: first word period is all zeros, captured word follows one period later
    tag = "R2";
    send_word(rand_word());
    send_word(rand_word());

    // R3: random words at the regular strobe spacing
    tag = "R3";
    for (int i = 0; i < 30; i++) send_word(rand_word());

    // R4: walk a single set bit across lanes and bit positions
    tag = "R4";
    for (int n = 0; n < NUM_LANES; n++)
      send_word({{(WORD_W-1){1'b0}}, 1'b1} << (n*SER_J + (n % SER_J)));
    send_word('0);

    // R5: clock lane against constant data
    tag = "R5";
    for (int i = 0; i < 4; i++) send_word((i % 2 == 0) ? '1 : '0);
    send_word('0);

    // R6: missing strobe drains every lane to zero
    tag = "R6";
    for (int i = 0; i < 2; i++) begin
      step(1'b1, rand_word());
      repeat (2*SER_J) step(1'b0, rand_word());
    end

    // R7: early strobes, back-to-back then random spacing
    tag = "R7";
    repeat (5) step(1'b1, rand_word());
    for (int i = 0; i < 40; i++) begin
      int gap;
      gap = $urandom_range(1, SER_J);
      step(1'b1, rand_word());
      repeat (gap-1) step(1'b0, rand_word());
    end
    repeat (SER_J) step(1'b0, rand_word());

    done = 1'b1;
    summary();
    $finish;
  end

endmodule